// File: doc/BRIEF.md
# Floating-Point NaN Guard Stage

This block sits directly behind a floating-point arithmetic datapath and applies NaN rules to its result before the result reaches the register file. Each accepted instruction carries its source operands, the raw result computed by the datapath, a format select (single or double) and the current control/status word. The block decides which value is written back and returns an updated status word. The caller owns the status register and writes the returned word back.

The NaN polarity follows the older convention. A NaN has an all-ones exponent and a nonzero fraction, and a fraction MSB of 1 marks it as signalling. Operands are examined first. A signalling operand NaN is replaced by the default quiet NaN of the format, and a quiet one is forwarded bit for bit. If no operand is a NaN but the raw result is, the default quiet NaN is written and the invalid-operation cause and sticky flag are raised. At the start of every instruction the six-bit cause field of the status word is cleared. All other status bits pass through unchanged.

Results come out of a register one cycle after acceptance. Single-precision values occupy the low 32 bits of the 64-bit result, and the upper 32 bits are zero.

Top module: `fpn_guard`

## Requirements
- R1: For every accepted instruction, out_status equals in_status with bits 17:12 cleared. The only exception is the invalid raise of R5. Bits 31:18 and 11:0 are never altered except bit 6 as in R5.
- R2: Only the first in_nsrc operands are examined, where in_nsrc 0 means none, 1 means op_a, and 2 or 3 mean both. When both are NaN, op_a decides the result. An operand NaN gives out_path = 1 (operand-NaN).
- R3: A signalling operand NaN is replaced by the default quiet NaN, which is 32'h7FBF_FFFF for single and 64'h7FF7_FFFF_FFFF_FFFF for double. A quiet operand NaN is written unchanged, and for single only its low 32 bits are used.
- R4: in_size encodes 1 = single and 2 = double. A value of 0 or 3 gives out_size_err = 1, out_wen = 0, out_result = 0 and out_path = 3, with the status word changed only as in R1.
- R5: If no operand is a NaN and the raw result is a NaN, the default quiet NaN is written with out_path = 2. Status bit 16 (invalid cause) and bit 6 (invalid sticky flag) are set, and other flag bits are kept.
- R6: The operand-NaN path raises no invalid. Bit 16 reads 0 and bit 6 equals its input value.
- R7: When neither NaN path fires and the size is legal, the raw result is written with out_wen = 1 and out_path = 0. For single, only the low 32 bits are kept and they are zero-extended.
- R8: in_ready is high whenever reset is low. Every accepted in_valid produces exactly one out_valid pulse in the next cycle, and back-to-back instructions are accepted.
- R9: During and directly after reset, out_valid, out_wen, out_result, out_status, out_path and out_size_err are all zero.
- R10: A value whose exponent is all ones and whose fraction is zero (infinity) is not a NaN. For single, only bits 31:0 are classified, and for double all 64 bits are classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept (high outside reset) |
| in_size | input | 2 | Format select: 1 single, 2 double, others illegal |
| in_nsrc | input | 2 | Number of source operands to examine |
| in_op_a | input | 64 | First source operand |
| in_op_b | input | 64 | Second source operand |
| in_raw | input | 64 | Result computed by the datapath |
| in_status | input | 32 | Current control/status word |
| out_valid | output | 1 | Result pulse, one cycle after acceptance |
| out_result | output | 64 | Value to write back |
| out_wen | output | 1 | Write enable for out_result |
| out_status | output | 32 | Updated control/status word |
| out_path | output | 2 | 0 normal, 1 operand NaN, 2 result NaN, 3 illegal size |
| out_size_err | output | 1 | Illegal format select |

## Verification
The bound checker covers several rules on every cycle. It requires the cause field to hold nothing but the invalid bit, all outer status bits to follow the input word, illegal sizes never to write, and the result-NaN path always to carry both invalid bits. It also checks that the operand-NaN path never does, that single results have a zero upper half, and that each acceptance produces exactly one pulse. Only the bench scenarios show the values themselves. These are which NaN is chosen, the operand priority, quiet-NaN pass-through, the default quiet NaN constants and infinities not being treated as NaNs.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    localparam int DATA_W      = 64;
    localparam int STAT_W      = 32;

    localparam int SGL_W       = 32;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;
    localparam int DBL_EXP_W   = 11;
    localparam int DBL_FRAC_W  = 52;

    localparam int CAUSE_LO    = 12;
    localparam int CAUSE_HI    = 17;
    localparam int INV_CAUSE   = 16;
    localparam int INV_FLAG    = 6;

    localparam logic [SGL_W-1:0]  SGL_DEFAULT_QNAN = 32'h7FBF_FFFF;
    localparam logic [DATA_W-1:0] DBL_DEFAULT_QNAN = 64'h7FF7_FFFF_FFFF_FFFF;

    typedef enum logic [1:0] {
        SZ_NONE   = 2'd0,
        SZ_SINGLE = 2'd1,
        SZ_DOUBLE = 2'd2,
        SZ_RSVD   = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        PATH_NORMAL   = 2'd0,
        PATH_OPND_NAN = 2'd1,
        PATH_RES_NAN  = 2'd2,
        PATH_BAD_SIZE = 2'd3
    } path_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } nan_class_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              wen;
        logic              raise_inv;
        logic              size_err;
        path_e             path;
    } verdict_t;

    function automatic logic size_legal(input logic [1:0] sz);
        return (sz == SZ_SINGLE) || (sz == SZ_DOUBLE);
    endfunction

    function automatic logic [DATA_W-1:0] default_qnan(input logic dbl);
        return dbl ? DBL_DEFAULT_QNAN : {{(DATA_W-SGL_W){1'b0}}, SGL_DEFAULT_QNAN};
    endfunction

    function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] v, input logic dbl);
        return dbl ? v : {{(DATA_W-SGL_W){1'b0}}, v[SGL_W-1:0]};
    endfunction

    function automatic logic [STAT_W-1:0] cause_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = CAUSE_LO; i <= CAUSE_HI; i++) begin
            m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] bits_i,
    input  logic         dbl_i,
    output nan_class_t   cls_o
);
    localparam int SE_LO = SGL_FRAC_W;
    localparam int SE_HI = SGL_FRAC_W + SGL_EXP_W - 1;
    localparam int DE_LO = DBL_FRAC_W;
    localparam int DE_HI = DBL_FRAC_W + DBL_EXP_W - 1;

    logic sgl_exp_ones, sgl_frac_nz, sgl_msb;
    logic dbl_exp_ones, dbl_frac_nz, dbl_msb;

    always_comb begin
        sgl_exp_ones = &bits_i[SE_HI:SE_LO];
        sgl_frac_nz  = |bits_i[SGL_FRAC_W-1:0];
        sgl_msb      = bits_i[SGL_FRAC_W-1];
        dbl_exp_ones = &bits_i[DE_HI:DE_LO];
        dbl_frac_nz  = |bits_i[DBL_FRAC_W-1:0];
        dbl_msb      = bits_i[DBL_FRAC_W-1];

        if (dbl_i) begin
            cls_o.is_nan  = dbl_exp_ones && dbl_frac_nz;
            cls_o.is_snan = dbl_exp_ones && dbl_frac_nz && dbl_msb;
        end else begin
            cls_o.is_nan  = sgl_exp_ones && sgl_frac_nz;
            cls_o.is_snan = sgl_exp_ones && sgl_frac_nz && sgl_msb;
        end
    end
endmodule

// File: rtl/fpn_resolve.sv
module fpn_resolve
    import fpn_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int NSRC_W  = 2
) (
    input  logic [NUM_SRC-1:0][DATA_W-1:0] ops_i,
    input  nan_class_t [NUM_SRC-1:0]       op_cls_i,
    input  logic [NSRC_W-1:0]              nsrc_i,
    input  logic [DATA_W-1:0]              raw_i,
    input  nan_class_t                     raw_cls_i,
    input  logic [1:0]                     size_i,
    output verdict_t                       verdict_o
);
    logic                 dbl;
    logic                 legal;
    logic [NUM_SRC-1:0]   active;
    logic                 opnd_hit;
    logic [DATA_W-1:0]    opnd_val;

    assign dbl   = (size_i == SZ_DOUBLE);
    assign legal = size_legal(size_i);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_active
        assign active[g] = (NSRC_W'(g) < nsrc_i);
    end

    // lowest index has priority: scan from the top so index 0 is applied last
    always_comb begin
        opnd_hit = 1'b0;
        opnd_val = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i] && op_cls_i[i].is_nan) begin
                opnd_hit = 1'b1;
                opnd_val = op_cls_i[i].is_snan ? default_qnan(dbl) : narrow(ops_i[i], dbl);
            end
        end
    end

    always_comb begin
        verdict_o = '0;
        if (!legal) begin
            verdict_o.path     = PATH_BAD_SIZE;
            verdict_o.size_err = 1'b1;
        end else if (opnd_hit) begin
            verdict_o.path  = PATH_OPND_NAN;
            verdict_o.value = opnd_val;
            verdict_o.wen   = 1'b1;
        end else if (raw_cls_i.is_nan) begin
            verdict_o.path      = PATH_RES_NAN;
            verdict_o.value     = default_qnan(dbl);
            verdict_o.wen       = 1'b1;
            verdict_o.raise_inv = 1'b1;
        end else begin
            verdict_o.path  = PATH_NORMAL;
            verdict_o.value = narrow(raw_i, dbl);
            verdict_o.wen   = 1'b1;
        end
    end
endmodule

// File: rtl/fpn_status.sv
module fpn_status
    import fpn_pkg::*;
(
    input  logic [STAT_W-1:0] stat_i,
    input  logic              raise_inv_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam logic [STAT_W-1:0] CLR_MASK = cause_mask();
    localparam logic [STAT_W-1:0] INV_BITS = (STAT_W'(1) << INV_CAUSE) | (STAT_W'(1) << INV_FLAG);

    always_comb begin
        stat_o = stat_i & ~CLR_MASK;
        if (raise_inv_i) begin
            stat_o = stat_o | INV_BITS;
        end
    end
endmodule

// File: rtl/fpn_guard.sv
module fpn_guard
    import fpn_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [1:0]  in_size,
    input  logic [1:0]  in_nsrc,
    input  logic [63:0] in_op_a,
    input  logic [63:0] in_op_b,
    input  logic [63:0] in_raw,
    input  logic [31:0] in_status,
    output logic        out_valid,
    output logic [63:0] out_result,
    output logic        out_wen,
    output logic [31:0] out_status,
    output logic [1:0]  out_path,
    output logic        out_size_err
);
    localparam int NUM_SRC = 2;
    localparam int NSRC_W  = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0][DATA_W-1:0] ops;
    nan_class_t [NUM_SRC-1:0]       op_cls;
    nan_class_t                     raw_cls;
    verdict_t                       verdict;
    logic [STAT_W-1:0]              stat_next;
    logic                           dbl;
    logic                           accept;

    assign ops[0]   = in_op_a;
    assign ops[1]   = in_op_b;
    assign dbl      = (in_size == SZ_DOUBLE);
    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cls
        fpn_classify #(.W(DATA_W)) u_cls (
            .bits_i (ops[g]),
            .dbl_i  (dbl),
            .cls_o  (op_cls[g])
        );
    end

    fpn_classify #(.W(DATA_W)) u_raw_cls (
        .bits_i (in_raw),
        .dbl_i  (dbl),
        .cls_o  (raw_cls)
    );

    fpn_resolve #(.NUM_SRC(NUM_SRC), .NSRC_W(NSRC_W)) u_resolve (
        .ops_i     (ops),
        .op_cls_i  (op_cls),
        .nsrc_i    (in_nsrc),
        .raw_i     (in_raw),
        .raw_cls_i (raw_cls),
        .size_i    (in_size),
        .verdict_o (verdict)
    );

    fpn_status u_status (
        .stat_i      (in_status),
        .raise_inv_i (verdict.raise_inv),
        .stat_o      (stat_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_wen      <= 1'b0;
            out_status   <= '0;
            out_path     <= PATH_NORMAL;
            out_size_err <= 1'b0;
        end else begin
            out_valid <= accept;
            out_wen   <= accept & verdict.wen;
            if (accept) begin
                out_result   <= verdict.value;
                out_status   <= stat_next;
                out_path     <= verdict.path;
                out_size_err <= verdict.size_err;
            end
        end
    end
endmodule

// File: rtl/fpn_guard_chk.sv
module fpn_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [1:0]  in_size,
    input logic [31:0] in_status,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_wen,
    input logic [31:0] out_status,
    input logic [1:0]  out_path,
    input logic        out_size_err
);
    logic acc;
    assign acc = in_valid && in_ready;

    AST_CAUSE_ONLY_INVALID: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_status[17:12] & 6'b101111) == 6'b0)); // R1
    AST_OUTER_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        acc |=> (out_status[31:18] == $past(in_status[31:18])) && (out_status[11:7] == $past(in_status[11:7])) && (out_status[5:0] == $past(in_status[5:0]))); // R1
    AST_BAD_SIZE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc && (in_size == 2'd0 || in_size == 2'd3)) |=> (out_size_err && !out_wen && out_path == 2'd3)); // R4
    AST_INVALID_RAISED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_path == 2'd2) |-> (out_status[16] && out_status[6])); // R5
    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (acc && in_status[6]) |=> out_status[6]); // R5
    AST_OPND_NO_INVALID: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_path == 2'd1) |-> !out_status[16]); // R6
    AST_LEGAL_WRITES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_size_err) |-> out_wen); // R7
    AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && in_size == 2'd1) |=> (out_result[63:32] == 32'h0)); // R7
    AST_ONE_PULSE_ON: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid); // R8
    AST_ONE_PULSE_OFF: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !out_valid); // R8
    AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst)
        in_ready); // R8
endmodule

bind fpn_guard fpn_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_size      (in_size),
    .in_status    (in_status),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_wen      (out_wen),
    .out_status   (out_status),
    .out_path     (out_path),
    .out_size_err (out_size_err)
);

// File: tb/fpn_guard_tb_top.sv
module fpn_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_size = 2'd0;
    logic [1:0]  in_nsrc = 2'd0;
    logic [63:0] in_op_a = '0;
    logic [63:0] in_op_b = '0;
    logic [63:0] in_raw = '0;
    logic [31:0] in_status = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_wen;
    logic [31:0] out_status;
    logic [1:0]  out_path;
    logic        out_size_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpn_guard dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_size(in_size), .in_nsrc(in_nsrc), .in_op_a(in_op_a), .in_op_b(in_op_b),
        .in_raw(in_raw), .in_status(in_status), .out_valid(out_valid),
        .out_result(out_result), .out_wen(out_wen), .out_status(out_status),
        .out_path(out_path), .out_size_err(out_size_err)
    );

    typedef struct packed {
        logic [1:0]  size;
        logic [1:0]  nsrc;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] raw;
        logic [31:0] st;
        logic [63:0] x_res;
        logic [31:0] x_st;
        logic [1:0]  x_path;
        logic        x_wen;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R7 single normal, R1 cause clear
        '{2'd1, 2'd2, 64'h3F80_0000, 64'h4000_0000, 64'h4040_0000, 32'hFFFF_FFFF, 64'h4040_0000, 32'hFFFC_0FFF, 2'd0, 1'b1, 4'd7},
        // R3 single signalling a
        '{2'd1, 2'd2, 64'h7FC0_0001, 64'h0, 64'h123, 32'h0, 64'h7FBF_FFFF, 32'h0, 2'd1, 1'b1, 4'd3},
        // R6 single quiet b passes, no invalid
        '{2'd1, 2'd2, 64'h3F80_0000, 64'h7F80_0005, 64'h1, 32'hA5A5_A5A5, 64'h7F80_0005, 32'hA5A4_05A5, 2'd1, 1'b1, 4'd6},
        // R2 both NaN, a wins
        '{2'd1, 2'd2, 64'h7F80_0007, 64'h7FC0_0001, 64'h1, 32'h0, 64'h7F80_0007, 32'h0, 2'd1, 1'b1, 4'd2},
        // R2 nsrc=1 ignores b
        '{2'd1, 2'd1, 64'h3F80_0000, 64'h7FC0_0001, 64'h42, 32'h0, 64'h42, 32'h0, 2'd0, 1'b1, 4'd2},
        // R2 nsrc=0 ignores a
        '{2'd1, 2'd0, 64'h7FC0_0001, 64'h0, 64'h42, 32'h0, 64'h42, 32'h0, 2'd0, 1'b1, 4'd2},
        // R2 nsrc=3 treated as two
        '{2'd1, 2'd3, 64'h0, 64'h7FC0_0001, 64'h42, 32'h0, 64'h7FBF_FFFF, 32'h0, 2'd1, 1'b1, 4'd2},
        // R5 single raw NaN, status zero
        '{2'd1, 2'd2, 64'h3F80_0000, 64'h0, 64'h7FC1_2345, 32'h0, 64'h7FBF_FFFF, 32'h0001_0040, 2'd2, 1'b1, 4'd5},
        // R5 raw NaN, other flags kept
        '{2'd1, 2'd2, 64'h3F80_0000, 64'h0, 64'h7F80_0001, 32'hA5A5_A5A5, 64'h7FBF_FFFF, 32'hA5A5_05E5, 2'd2, 1'b1, 4'd5},
        // R7 double normal
        '{2'd2, 2'd2, 64'h3FF0_0000_0000_0000, 64'h0, 64'h4000_0000_0000_0000, 32'hFFFF_FFFF, 64'h4000_0000_0000_0000, 32'hFFFC_0FFF, 2'd0, 1'b1, 4'd7},
        // R3 double signalling a
        '{2'd2, 2'd2, 64'h7FF8_0000_0000_0001, 64'h0, 64'h0, 32'h0, 64'h7FF7_FFFF_FFFF_FFFF, 32'h0, 2'd1, 1'b1, 4'd3},
        // R3 double quiet b passes
        '{2'd2, 2'd2, 64'h0, 64'h7FF0_0000_0000_0003, 64'h0, 32'h0, 64'h7FF0_0000_0000_0003, 32'h0, 2'd1, 1'b1, 4'd3},
        // R5 double raw NaN
        '{2'd2, 2'd2, 64'h0, 64'h0, 64'h7FF0_0000_0000_0001, 32'h0, 64'h7FF7_FFFF_FFFF_FFFF, 32'h0001_0040, 2'd2, 1'b1, 4'd5},
        // R10 single infinities are not NaN
        '{2'd1, 2'd2, 64'h7F80_0000, 64'hFF80_0000, 64'h7F80_0000, 32'h0, 64'h7F80_0000, 32'h0, 2'd0, 1'b1, 4'd10},
        // R10 double infinity raw; low half looking like single NaN ignored
        '{2'd2, 2'd2, 64'h0000_0000_7FC0_0001, 64'h0, 64'h7FF0_0000_0000_0000, 32'h0, 64'h7FF0_0000_0000_0000, 32'h0, 2'd0, 1'b1, 4'd10},
        // R7 single upper half dropped
        '{2'd1, 2'd2, 64'hFFFF_FFFF_3F80_0000, 64'h0, 64'hDEAD_BEEF_4040_0000, 32'h0, 64'h4040_0000, 32'h0, 2'd0, 1'b1, 4'd7},
        // R3 single quiet operand with upper garbage
        '{2'd1, 2'd2, 64'h1234_5678_7F80_0005, 64'h0, 64'h0, 32'h0, 64'h7F80_0005, 32'h0, 2'd1, 1'b1, 4'd3},
        // R4 size 0 illegal
        '{2'd0, 2'd2, 64'h7FC0_0001, 64'h0, 64'h7FC0_0001, 32'hFFFF_FFFF, 64'h0, 32'hFFFC_0FFF, 2'd3, 1'b0, 4'd4},
        // R4 size 3 illegal
        '{2'd3, 2'd2, 64'h0, 64'h0, 64'h4040_0000, 32'h0003_F000, 64'h0, 32'h0, 2'd3, 1'b0, 4'd4}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid  = 1'b1;
        in_size   = v.size;
        in_nsrc   = v.nsrc;
        in_op_a   = v.a;
        in_op_b   = v.b;
        in_raw    = v.raw;
        in_status = v.st;
    endtask

    task automatic expect_vec(input vec_t v, input int idx);
        string r;
        r = $sformatf("R%0d(vec %0d)", v.req, idx);
        check(out_valid == 1'b1, r, "out_valid", 64'(out_valid), 64'd1);
        check(out_result == v.x_res, r, "out_result", out_result, v.x_res);
        check(out_status == v.x_st, r, "out_status", 64'(out_status), 64'(v.x_st));
        check(out_path == v.x_path, r, "out_path", 64'(out_path), 64'(v.x_path));
        check(out_wen == v.x_wen, r, "out_wen", 64'(out_wen), 64'(v.x_wen));
        check(out_size_err == (v.x_path == 2'd3), r, "out_size_err", 64'(out_size_err), 64'(v.x_path == 2'd3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0 && out_wen == 1'b0 && out_size_err == 1'b0, "R9", "ctrl in reset",
              {61'b0, out_valid, out_wen, out_size_err}, 64'd0);
        check(out_result == '0 && out_status == '0 && out_path == 2'd0, "R9", "data in reset",
              out_result | 64'(out_status), 64'd0);
        check(in_ready == 1'b0, "R8", "in_ready in reset", 64'(in_ready), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "in_ready after reset", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            expect_vec(VECS[i], i);
            @(negedge clk);
            check(out_valid == 1'b0 && out_wen == 1'b0, "R8", "single pulse",
                  {62'b0, out_valid, out_wen}, 64'd0);
        end

        // R8 back-to-back acceptance
        drive(VECS[1]);
        @(negedge clk);
        expect_vec(VECS[1], 1);
        drive(VECS[12]);
        @(negedge clk);
        expect_vec(VECS[12], 12);
        drive(VECS[0]);
        @(negedge clk);
        in_valid = 1'b0;
        expect_vec(VECS[0], 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "no pulse without valid", 64'(out_valid), 64'd0);

        // R9 reset mid-stream clears outputs
        drive(VECS[7]);
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0 && out_status == '0, "R9", "reset clears",
              {31'b0, out_valid, out_status}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule